// File: doc/BRIEF.md
# Comparator Change-Interrupt Controller

This block holds the registers and the interrupt logic for one analog comparator in a small microcontroller. The raw comparator decision enters without any timing relation to the clock. It passes through a synchronizer and then through an optional inversion. A mode field can switch the comparator off, and the result is the comparator output bit that software reads.

A change latch stores the output value that software last saw. When the live output differs from that stored value, a sticky interrupt flag is raised on every cycle. Any read or write of the control register copies the live output into the latch, and that ends the mismatch. Once the mismatch has ended, software can clear the flag by writing 0 to it. The interrupt request is the flag gated by three enables: a local comparator enable, a peripheral-group enable and a global enable.

The register bus is plain. It has an address, a read strobe, a write strobe and write data, and the read data is returned combinationally for the addressed register. There is no stream interface, so no valid/ready handshake applies. The read strobe matters only for its side effect on the change latch.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: The raw comparator input passes through two clock flops. A change on it shows in the output bit (control register bit 6) after exactly two rising edges.
- R2: When the mode field is not 7, the output bit equals the synchronized input XOR the invert bit (control register bit 4).
- R3: Mode field value 7 (control register bits 2:0) switches the comparator off. The output bit is then forced to 0 and input changes raise no flag.
- R4: The control register (address 0) resets to 0x00. Bits 4, 3 and 2:0 are writable. A write to bit 6 has no effect. Bits 7 and 5 always read 0.
- R5: An output change that arrives with no control-register access sets the flag (bit 3 of the flag register, address 1) on the third rising edge after the raw input changed. This happens whatever the enables are.
- R6: While a mismatch remains, the flag is set again every cycle. A write of 0 to the flag leaves it at 1.
- R7: A read strobe or a write strobe at the control register loads the current output into the change latch. A write loads the output that the newly written settings give. After such an access, a write of 0 clears the flag and the flag stays clear.
- R8: Writing a 1 to flag bit 3 sets the flag, which gives a software-raised interrupt. Writing a 0 with no mismatch present clears it. The other bits of the flag register read 0.
- R9: `irq_o` is 1 only when the flag, the local enable (bit 3 of address 2), the peripheral enable (bit 6 of address 3) and the global enable (bit 7 of address 3) are all 1.
- R10: When a control-register read happens in the same cycle that the output first differs from the latch, the latch takes the new value and the flag is not set.
- R11: After reset, the latch follows the output for three cycles while the synchronizer fills. A raw input held at 1 through reset therefore raises no flag.
- R12: The enable registers reset to 0. Only their named bits are writable, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Asynchronous raw comparator decision |
| bus_addr_i | input | 4 | Register address |
| bus_rd_i | input | 1 | Read strobe; the only side effect is at the control register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data of the addressed register |
| cmp_out_o | output | 1 | Comparator output bit after inversion and mode gating |
| cmp_insel_o | output | 1 | Input-select setting to the analog front end |
| cmp_mode_o | output | 3 | Mode setting to the analog front end |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A change latch left holding a stale value shows within one cycle as a flag that will not clear, even after a control-register read. A latch that is updated when it should not be shows as a missing flag three edges after an input change. The synchronizer depth can be seen directly: the output bit must flip on the second edge and the flag on the third, and a check one edge early or late exposes any extra or missing flop. The enable gating and the software set and clear paths each reach `irq_o` or the flag register in the cycle after the write.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  // bit positions used by software
  localparam int CTRL_OUT_BIT = 6;
  localparam int CTRL_INV_BIT = 4;
  localparam int CTRL_SEL_BIT = 3;
  localparam int FLAG_BIT     = 3;
  localparam int LOCAL_EN_BIT = 3;
  localparam int PERIPH_EN_BIT = 6;
  localparam int GLOBAL_EN_BIT = 7;
  localparam logic [2:0] MODE_OFF = 3'd7;

  typedef struct packed {
    logic       inv;
    logic       sel;
    logic [2:0] mode;
  } cmp_ctrl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q[STAGES-1] == $past(chain_q[STAGES-2])); // R1
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [4:0] wdata_i,
  input  logic       sample_i,
  output cmp_ctrl_t  ctrl_o,
  output logic       out_o,
  output logic       wr_out_o,
  output logic       off_o
);
  cmp_ctrl_t ctrl_q;
  cmp_ctrl_t ctrl_new;

  always_comb begin
    ctrl_new.inv  = wdata_i[CTRL_INV_BIT];
    ctrl_new.sel  = wdata_i[CTRL_SEL_BIT];
    ctrl_new.mode = wdata_i[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_new;
  end

  assign off_o    = (ctrl_q.mode == MODE_OFF);
  assign out_o    = off_o ? 1'b0 : (sample_i ^ ctrl_q.inv);
  // output the block would show once the pending write has landed
  assign wr_out_o = (ctrl_new.mode == MODE_OFF) ? 1'b0 : (sample_i ^ ctrl_new.inv);
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/cmp_change_det.sv
module cmp_change_det
  import cmp_irq_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic out_i,
  input  logic wr_out_i,
  input  logic off_i,
  input  logic ctrl_rd_i,
  input  logic ctrl_wr_i,
  input  logic flag_wr_i,
  input  logic flag_wbit_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] settle_q;
  logic             settling;
  logic             seen_q;
  logic             mismatch;
  logic             access;
  logic             hw_set;
  logic             sw_set;
  logic             flag_q;

  assign settling = (settle_q != '0);
  assign access   = ctrl_rd_i | ctrl_wr_i;
  assign mismatch = (out_i != seen_q) & ~off_i & ~settling;
  assign hw_set   = mismatch & ~access;
  assign sw_set   = flag_wr_i & flag_wbit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        settle_q <= CNT_W'(SETTLE);
    else if (settling) settle_q <= settle_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              seen_q <= 1'b0;
    else if (ctrl_wr_i)                      seen_q <= wr_out_i;
    else if (ctrl_rd_i || off_i || settling) seen_q <= out_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (hw_set || sw_set) flag_q <= 1'b1;
    else if (flag_wr_i)        flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLAG_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !access) |=> flag_q); // R6
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(mismatch || sw_set)); // R5
  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(flag_wr_i && !flag_wbit_i)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (off_i && !ctrl_wr_i) |=> !$rose(flag_q) || $past(sw_set)); // R3
endmodule

// File: rtl/cmp_irq_gate.sv
module cmp_irq_gate
  import cmp_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr_i,
  input  logic       intc_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       flag_i,
  output logic       local_en_o,
  output logic       periph_en_o,
  output logic       global_en_o,
  output logic       irq_o
);
  logic local_q, periph_q, global_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       local_q <= 1'b0;
    else if (en_wr_i) local_q <= wdata_i[LOCAL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periph_q <= 1'b0;
      global_q <= 1'b0;
    end else if (intc_wr_i) begin
      periph_q <= wdata_i[PERIPH_EN_BIT];
      global_q <= wdata_i[GLOBAL_EN_BIT];
    end
  end

  assign local_en_o  = local_q;
  assign periph_en_o = periph_q;
  assign global_en_o = global_q;
  assign irq_o       = flag_i & local_q & periph_q & global_q;

  AST_GLOBAL_OFF_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (intc_wr_i && !wdata_i[GLOBAL_EN_BIT]) |=> !irq_o); // R9
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int             ADDR_W      = 4,
  parameter int             SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] A_CTRL   = 4'h0,
  parameter logic [ADDR_W-1:0] A_FLAG   = 4'h1,
  parameter logic [ADDR_W-1:0] A_EN     = 4'h2,
  parameter logic [ADDR_W-1:0] A_INTC   = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              cmp_out_o,
  output logic              cmp_insel_o,
  output logic [2:0]        cmp_mode_o,
  output logic              irq_o
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic      sample;
  logic      sel_ctrl, sel_flag, sel_en, sel_intc;
  cmp_ctrl_t ctrl;
  logic      out_now, out_wr, off;
  logic      flag;
  logic      local_en, periph_en, global_en;

  assign sel_ctrl = (bus_addr_i == A_CTRL);
  assign sel_flag = (bus_addr_i == A_FLAG);
  assign sel_en   = (bus_addr_i == A_EN);
  assign sel_intc = (bus_addr_i == A_INTC);

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw_i),
    .q_o   (sample)
  );

  cmp_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr_i & sel_ctrl),
    .wdata_i  (bus_wdata_i[4:0]),
    .sample_i (sample),
    .ctrl_o   (ctrl),
    .out_o    (out_now),
    .wr_out_o (out_wr),
    .off_o    (off)
  );

  cmp_change_det #(.SETTLE(SETTLE)) u_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_i       (out_now),
    .wr_out_i    (out_wr),
    .off_i       (off),
    .ctrl_rd_i   (bus_rd_i & sel_ctrl),
    .ctrl_wr_i   (bus_wr_i & sel_ctrl),
    .flag_wr_i   (bus_wr_i & sel_flag),
    .flag_wbit_i (bus_wdata_i[FLAG_BIT]),
    .flag_o      (flag)
  );

  cmp_irq_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_wr_i     (bus_wr_i & sel_en),
    .intc_wr_i   (bus_wr_i & sel_intc),
    .wdata_i     (bus_wdata_i),
    .flag_i      (flag),
    .local_en_o  (local_en),
    .periph_en_o (periph_en),
    .global_en_o (global_en),
    .irq_o       (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel_ctrl) begin
      bus_rdata_o[CTRL_OUT_BIT] = out_now;
      bus_rdata_o[CTRL_INV_BIT] = ctrl.inv;
      bus_rdata_o[CTRL_SEL_BIT] = ctrl.sel;
      bus_rdata_o[2:0]          = ctrl.mode;
    end else if (sel_flag) begin
      bus_rdata_o[FLAG_BIT] = flag;
    end else if (sel_en) begin
      bus_rdata_o[LOCAL_EN_BIT] = local_en;
    end else if (sel_intc) begin
      bus_rdata_o[PERIPH_EN_BIT] = periph_en;
      bus_rdata_o[GLOBAL_EN_BIT] = global_en;
    end
  end

  assign cmp_out_o   = out_now;
  assign cmp_insel_o = ctrl.sel;
  assign cmp_mode_o  = ctrl.mode;

  AST_READ_ENDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && sel_ctrl && !bus_wr_i && !(bus_wr_i && sel_flag)) |=> !$rose(flag)); // R10
endmodule

// File: tb/cmp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cmp_irq_ctrl_tb;
  localparam logic [3:0] A_CTRL = 4'h0, A_FLAG = 4'h1, A_EN = 4'h2, A_INTC = 4'h3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic [3:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cout, insel, irq;
  logic [2:0] mode;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .bus_addr_i(addr),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cmp_out_o(cout), .cmp_insel_o(insel), .cmp_mode_o(mode), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    brd(A_CTRL);
    bwr(A_FLAG, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    wait_n(5);
    peek(A_CTRL, d); check(d == 8'h00, "R4 ctrl reset", d, 8'h00);
    peek(A_FLAG, d); check(d == 8'h00, "R11 flag after reset", d, 8'h00);
    peek(A_EN, d);   check(d == 8'h00, "R12 enable reset", d, 8'h00);
    peek(A_INTC, d); check(d == 8'h00, "R12 intc reset", d, 8'h00);
    check(irq == 1'b0, "R9 irq reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    bwr(A_CTRL, 8'hFF);
    peek(A_CTRL, d); check(d == 8'h1F, "R4 ctrl writable bits", d, 8'h1F);
    check(mode == 3'd7 && insel, "R4 mode/insel pins", {4'd0, insel, mode}, 8'h0F);
    bwr(A_FLAG, 8'hF7);
    peek(A_FLAG, d); check(d == 8'h00, "R8 flag other bits", d, 8'h00);
    bwr(A_EN, 8'hFF);
    peek(A_EN, d); check(d == 8'h08, "R12 enable bits", d, 8'h08);
    bwr(A_INTC, 8'hFF);
    peek(A_INTC, d); check(d == 8'hC0, "R12 intc bits", d, 8'hC0);
    bwr(A_EN, 8'h00); bwr(A_INTC, 8'h00); bwr(A_CTRL, 8'h00);
    wait_n(2);
    peek(A_FLAG, d); check(d == 8'h00, "R7 flag after ctrl writes", d, 8'h00);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    logic exp_old;
    exp_old = raw;
    @(negedge clk); raw = ~raw;
    @(negedge clk);
    peek(A_CTRL, d); check(d[6] == exp_old, "R1 out after one edge", d, {1'b0, exp_old, 6'd0});
    @(negedge clk);
    peek(A_CTRL, d); check(d[6] == raw, "R1 out after two edges", d, {1'b0, raw, 6'd0});
    peek(A_FLAG, d); check(d == 8'h00, "R5 flag not early", d, 8'h00);
    @(negedge clk);
    peek(A_FLAG, d); check(d == 8'h08, "R5 flag on third edge, enables off", d, 8'h08);
    check(irq == 1'b0, "R9 irq masked", {7'd0, irq}, 8'h00);
    clean();
  endtask

  task automatic t_persist();
    logic [7:0] d;
    @(negedge clk); raw = ~raw;
    wait_n(4);
    bwr(A_FLAG, 8'h00);
    peek(A_FLAG, d); check(d == 8'h08, "R6 clear ignored during mismatch", d, 8'h08);
    wait_n(3);
    peek(A_FLAG, d); check(d == 8'h08, "R6 flag keeps set", d, 8'h08);
    brd(A_CTRL);
    bwr(A_FLAG, 8'h00);
    wait_n(3);
    peek(A_FLAG, d); check(d == 8'h00, "R7 read resync then clear", d, 8'h00);
    @(negedge clk); raw = ~raw;
    wait_n(4);
    bwr(A_CTRL, 8'h00);
    bwr(A_FLAG, 8'h00);
    wait_n(3);
    peek(A_FLAG, d); check(d == 8'h00, "R7 write resync then clear", d, 8'h00);
  endtask

  task automatic t_soft();
    logic [7:0] d;
    bwr(A_FLAG, 8'h08);
    peek(A_FLAG, d); check(d == 8'h08, "R8 software set", d, 8'h08);
    bwr(A_FLAG, 8'h00);
    peek(A_FLAG, d); check(d == 8'h00, "R8 software clear", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    bwr(A_FLAG, 8'h08);
    check(irq == 1'b0, "R9 no enables", {7'd0, irq}, 8'h00);
    bwr(A_EN, 8'h08);
    check(irq == 1'b0, "R9 local only", {7'd0, irq}, 8'h00);
    bwr(A_INTC, 8'h40);
    check(irq == 1'b0, "R9 global missing", {7'd0, irq}, 8'h00);
    bwr(A_INTC, 8'hC0);
    check(irq == 1'b1, "R9 all enabled", {7'd0, irq}, 8'h01);
    bwr(A_INTC, 8'h40);
    check(irq == 1'b0, "R9 global cleared", {7'd0, irq}, 8'h00);
    peek(A_FLAG, d); check(d == 8'h08, "R9 flag kept", d, 8'h08);
    bwr(A_INTC, 8'hC0);
    bwr(A_FLAG, 8'h00);
    check(irq == 1'b0, "R9 flag cleared", {7'd0, irq}, 8'h00);
    bwr(A_EN, 8'h00); bwr(A_INTC, 8'h00);
  endtask

  task automatic t_invert();
    logic [7:0] d;
    bwr(A_CTRL, 8'h10);
    peek(A_CTRL, d); check(d[6] == ~raw, "R2 inverted output", d, {1'b0, ~raw, 6'h10});
    wait_n(3);
    peek(A_FLAG, d); check(d == 8'h00, "R7 invert write resyncs", d, 8'h00);
    bwr(A_CTRL, 8'h00);
    peek(A_CTRL, d); check(d[6] == raw, "R2 plain output", d, {1'b0, raw, 6'd0});
  endtask

  task automatic t_suppress();
    logic [7:0] d;
    @(negedge clk); raw = ~raw;
    @(negedge clk);
    @(negedge clk); addr = A_CTRL; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    wait_n(3);
    peek(A_FLAG, d); check(d == 8'h00, "R10 same-cycle read suppresses", d, 8'h00);
    peek(A_CTRL, d); check(d[6] == raw, "R10 out updated", d, {1'b0, raw, 6'd0});
  endtask

  task automatic t_off();
    logic [7:0] d;
    bwr(A_CTRL, 8'h07);
    @(negedge clk); raw = ~raw;
    wait_n(4);
    peek(A_CTRL, d); check(d == 8'h07, "R3 out forced 0", d, 8'h07);
    @(negedge clk); raw = ~raw;
    wait_n(4);
    peek(A_FLAG, d); check(d == 8'h00, "R3 no flag while off", d, 8'h00);
    bwr(A_CTRL, 8'h00);
    wait_n(3);
    peek(A_FLAG, d); check(d == 8'h00, "R3 no flag on re-enable", d, 8'h00);
    peek(A_CTRL, d); check(d[6] == raw, "R3 out follows after re-enable", d, {1'b0, raw, 6'd0});
  endtask

  task automatic t_warm();
    logic [7:0] d;
    @(negedge clk); raw = 1'b1; rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(6);
    peek(A_FLAG, d); check(d == 8'h00, "R11 no flag after reset with input high", d, 8'h00);
    peek(A_CTRL, d); check(d == 8'h40, "R11 out high after settle", d, 8'h40);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_latency();
    t_persist();
    t_soft();
    t_irq();
    t_invert();
    t_suppress();
    t_off();
    t_warm();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule